// File: doc/BRIEF.md
# Serial Potentiometer Command Decoder

This block is the serial slave front end of a single-channel digital potentiometer. A host frames each command with an active-low chip select. It shifts bits in on the rising edge of SCK and takes data back on falling-edge transitions, which is SPI mode 0. The decoder checks an identification byte against a fixed device type and two strap pins. It then decodes an instruction byte and carries out reads, writes and transfers between a volatile wiper position and a 16-entry register file. The register file is organised as four banks of four bytes, and a write to it stands in for a nonvolatile store. It also offers an open-ended step mode, in which each SCK pulse nudges the wiper up or down.

SCK, CS, SI and HOLD are expected to arrive already synchronised to `clk`. The SCK high and low phases must each last at least two `clk` cycles. The serial output comes as a data bit plus an output enable, and the pad driver sits outside the block. Three submodules sit under the top: the control state machine, the register file with its store-busy timer, and the wiper counter.

The control machine has eight states. IDLE waits for a falling CS edge and then enters IDENT. IDENT takes eight bits and goes to OPCODE on a match or to DISCARD otherwise. OPCODE goes to one of four states: WR_DATA for writes, RD_DATA for reads, STEPPING for increment/decrement, or CLOSING for the two transfers. Any rejected opcode goes to DISCARD. WR_DATA and RD_DATA each move to CLOSING after one byte. STEPPING, CLOSING and DISCARD hold until CS rises. A high CS forces every state back to IDLE.

Top module: `spi_pot_decoder`

## Requirements
- R1: Only a falling CS edge opens a frame, so a CS held low from reset onward accepts nothing. `so_oe` is 0 whenever CS is high.
- R2: The first byte must equal `{4'b0101, 2'b00, dev_addr}`. Otherwise every later bit of the frame is ignored.
- R3: In the second byte, bits [7:4] are the opcode, [3:2] the register and [1:0] the bank. The register-file index is `{bank, register}`. Opcodes are 1001 read wiper, 1010 write wiper, 1011 read register, 1100 write register, 1101 register-to-wiper, 1110 wiper-to-register, 0010 step and 0101 status. A read returns its byte MSB first on `so`, and each bit changes after a falling SCK edge.
- R4: The write-wiper and write-register commands take a third byte, MSB first. They take effect at the CS rise that closes a frame ending on a byte boundary.
- R5: Register-to-wiper loads the wiper from bank-0 register [3:2]. Wiper-to-register stores the wiper into that register. Both are two-byte commands applied at CS rise.
- R6: Wiper read, wiper write, step and both transfers need bank 00. With any other bank they have no effect. Undefined opcodes are also ignored.
- R7: In step mode each rising SCK edge raises the wiper by one when SI is 1 and lowers it by one when SI is 0. The wiper saturates at 0x00 and 0xFF, and the mode lasts until CS rises.
- R8: Status returns `{7'b0, wip}`. `wip` is 1 for NV_CYCLES clocks after a register store.
- R9: A register store (write-register or wiper-to-register) is dropped when `wp_n` is 0 or while `wip` is 1.
- R10: While HOLD is active, SCK edges are ignored, the frame position is kept and `so_oe` is 0. HOLD is sampled only while SCK is low.
- R11: If CS rises in the middle of a byte, the frame changes no register.
- R12: After reset every register holds RESET_VAL, and the wiper is loaded from bank-0 register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, synchronised |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for `so` |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Store protect, active low |
| dev_addr | input | 2 | Strap address compared in the first byte |
| wiper_pos | output | 8 | Current wiper position |

## Verification
The bench probes the ID byte with a wrong strap, a wrong type nibble and nonzero reserved bits. A decoder that compared only part of the byte would let the following write move the wiper. It sends wiper and transfer commands with a nonzero bank and a step frame on bank 01. Lax bank checks would load from the wrong register or step the wiper. It drives the wiper to both ends in step mode, where missing saturation would wrap to 0x00 or 0xFF. It cuts a write off mid-byte, where a commit without a boundary check would load the partial value. It pauses a read with HOLD while SCK pulses, and a design that counted those pulses would return a shifted byte. Finally, it issues a second store during the busy window and one with protect low, and either store landing shows up when the register is read back.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;

    localparam int BYTE_W = 8;
    localparam int NREG   = 16;
    localparam int IDX_W  = $clog2(NREG);

    localparam logic [3:0] DEV_TYPE = 4'b0101;

    localparam logic [3:0] OP_STEP = 4'b0010;
    localparam logic [3:0] OP_STAT = 4'b0101;
    localparam logic [3:0] OP_RWCR = 4'b1001;
    localparam logic [3:0] OP_WWCR = 4'b1010;
    localparam logic [3:0] OP_RREG = 4'b1011;
    localparam logic [3:0] OP_WREG = 4'b1100;
    localparam logic [3:0] OP_LOAD = 4'b1101;
    localparam logic [3:0] OP_SAVE = 4'b1110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IDENT,
        ST_OPCODE,
        ST_WR_DATA,
        ST_RD_DATA,
        ST_STEPPING,
        ST_CLOSING,
        ST_DISCARD
    } fsm_t;

endpackage

// File: rtl/spi_pot_regfile.sv
module spi_pot_regfile
    import spi_pot_pkg::*;
#(
    parameter int          NV_CYCLES = 400,
    parameter logic [7:0]  RESET_VAL = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic [BYTE_W-1:0] dr0_o,
    output logic              wip_o
);
    localparam int CW = $clog2(NV_CYCLES + 1);

    logic [BYTE_W-1:0] cells [NREG];
    logic [CW-1:0]     busy_q;

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        logic [BYTE_W-1:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q <= RESET_VAL;
            else if (we_i && waddr_i == IDX_W'(g))
                cell_q <= wdata_i;
        end
        assign cells[g] = cell_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_q <= '0;
        else if (we_i)
            busy_q <= CW'(NV_CYCLES);
        else if (busy_q != '0)
            busy_q <= busy_q - CW'(1);
    end

    assign rdata_o = cells[raddr_i];
    assign dr0_o   = cells[0];
    assign wip_o   = (busy_q != '0);

    // R9
    store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> !wip_o);

    // R8
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip_o) |-> $past(we_i));

endmodule

// File: rtl/spi_pot_wiper.sv
module spi_pot_wiper
    import spi_pot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] recall_val_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_val_i,
    input  logic              up_i,
    input  logic              dn_i,
    output logic [BYTE_W-1:0] pos_o
);
    localparam logic [BYTE_W-1:0] TOP = '1;

    logic              boot_q;
    logic [BYTE_W-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_q <= 1'b1;
            pos_q  <= '0;
        end else begin
            boot_q <= 1'b0;
            if (boot_q)
                pos_q <= recall_val_i;
            else if (load_i)
                pos_q <= load_val_i;
            else if (up_i && pos_q != TOP)
                pos_q <= pos_q + BYTE_W'(1);
            else if (dn_i && pos_q != '0)
                pos_q <= pos_q - BYTE_W'(1);
        end
    end

    assign pos_o = pos_q;

    // R7
    top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_q && !load_i && up_i && pos_q == TOP) |=> pos_q == TOP);

    // R7
    floor_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_q && !load_i && !up_i && dn_i && pos_q == '0) |=> pos_q == '0);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_q && !load_i && !up_i && !dn_i) |=> $stable(pos_q));

endmodule

// File: rtl/spi_pot_ctrl.sv
module spi_pot_ctrl
    import spi_pot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    input  logic              wp_n,
    input  logic [1:0]        dev_addr,
    input  logic [BYTE_W-1:0] wiper_i,
    input  logic [BYTE_W-1:0] rf_rdata_i,
    input  logic              wip_i,
    output logic [IDX_W-1:0]  rf_raddr_o,
    output logic              rf_we_o,
    output logic [IDX_W-1:0]  rf_waddr_o,
    output logic [BYTE_W-1:0] rf_wdata_o,
    output logic              wcr_load_o,
    output logic [BYTE_W-1:0] wcr_val_o,
    output logic              step_up_o,
    output logic              step_dn_o,
    output logic              so_o,
    output logic              so_oe_o
);
    fsm_t state_q, state_d, instr_next;

    logic              sck_q, cs_q, hold_q, so_q, pend_q;
    logic [2:0]        cnt_q;
    logic [6:0]        sh_q;
    logic [3:0]        op_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] data_q, so_sh_q;

    logic              sck_rise, sck_fall, cs_fall, cs_rise, byte_end;
    logic              id_ok, bank_zero, commit, nv_ok;
    logic [BYTE_W-1:0] byte_now, rd_value;
    logic [3:0]        opc;
    logic [IDX_W-1:0]  idx_now;

    assign sck_rise  = sck && !sck_q && !cs_n && !hold_q;
    assign sck_fall  = !sck && sck_q && !cs_n && !hold_q;
    assign cs_fall   = cs_q && !cs_n;
    assign cs_rise   = cs_n && !cs_q;
    assign byte_end  = sck_rise && (cnt_q == 3'd7);
    assign byte_now  = {sh_q, si};
    assign opc       = byte_now[7:4];
    assign idx_now   = {byte_now[1:0], byte_now[3:2]};
    assign bank_zero = (byte_now[1:0] == 2'b00);
    assign id_ok     = (byte_now == {DEV_TYPE, 2'b00, dev_addr});

    // Instruction byte decode: where the frame continues
    always_comb begin
        unique case (opc)
            OP_STEP:          instr_next = bank_zero ? ST_STEPPING : ST_DISCARD;
            OP_RWCR:          instr_next = bank_zero ? ST_RD_DATA  : ST_DISCARD;
            OP_WWCR:          instr_next = bank_zero ? ST_WR_DATA  : ST_DISCARD;
            OP_RREG, OP_STAT: instr_next = ST_RD_DATA;
            OP_WREG:          instr_next = ST_WR_DATA;
            OP_LOAD, OP_SAVE: instr_next = bank_zero ? ST_CLOSING  : ST_DISCARD;
            default:          instr_next = ST_DISCARD;
        endcase
    end

    always_comb begin
        unique case (opc)
            OP_RWCR: rd_value = wiper_i;
            OP_STAT: rd_value = {{(BYTE_W-1){1'b0}}, wip_i};
            default: rd_value = rf_rdata_i;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cs_fall)  state_d = ST_IDENT;
            ST_IDENT:    if (byte_end) state_d = id_ok ? ST_OPCODE : ST_DISCARD;
            ST_OPCODE:   if (byte_end) state_d = instr_next;
            ST_WR_DATA:  if (byte_end) state_d = ST_CLOSING;
            ST_RD_DATA:  if (byte_end) state_d = ST_CLOSING;
            ST_STEPPING: state_d = ST_STEPPING;
            ST_CLOSING:  state_d = ST_CLOSING;
            ST_DISCARD:  state_d = ST_DISCARD;
        endcase
        if (cs_n)
            state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b0;
            hold_q  <= 1'b0;
            cnt_q   <= '0;
            sh_q    <= '0;
            op_q    <= '0;
            idx_q   <= '0;
            data_q  <= '0;
            so_sh_q <= '0;
            so_q    <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n)
                hold_q <= 1'b0;
            else if (!sck && !sck_q)
                hold_q <= !hold_n;
            if (cs_n) begin
                cnt_q <= '0;
                sh_q  <= '0;
            end else if (sck_rise) begin
                cnt_q <= cnt_q + 3'd1;
                sh_q  <= byte_now[6:0];
            end
            if (cs_fall)
                pend_q <= 1'b0;
            if (state_q == ST_OPCODE && byte_end) begin
                op_q    <= opc;
                idx_q   <= idx_now;
                so_sh_q <= rd_value;
                if (instr_next == ST_CLOSING)
                    pend_q <= 1'b1;
            end
            if (state_q == ST_WR_DATA && byte_end) begin
                data_q <= byte_now;
                pend_q <= 1'b1;
            end
            if (state_q == ST_RD_DATA && sck_fall) begin
                so_q    <= so_sh_q[BYTE_W-1];
                so_sh_q <= {so_sh_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // Outputs
    always_comb begin
        commit     = cs_rise && pend_q && (cnt_q == 3'd0) && (state_q == ST_CLOSING);
        nv_ok      = wp_n && !wip_i;
        rf_raddr_o = (state_q == ST_OPCODE) ? idx_now : idx_q;
        rf_waddr_o = idx_q;
        rf_wdata_o = (op_q == OP_SAVE) ? wiper_i : data_q;
        rf_we_o    = commit && nv_ok && (op_q == OP_WREG || op_q == OP_SAVE);
        wcr_val_o  = (op_q == OP_LOAD) ? rf_rdata_i : data_q;
        wcr_load_o = commit && (op_q == OP_WWCR || op_q == OP_LOAD);
        step_up_o  = (state_q == ST_STEPPING) && sck_rise && si;
        step_dn_o  = (state_q == ST_STEPPING) && sck_rise && !si;
        so_o       = so_q;
        so_oe_o    = (state_q == ST_RD_DATA) && !cs_n && !hold_q;
    end

    // R6
    discard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCARD) |-> !(rf_we_o || wcr_load_o || step_up_o || step_dn_o));

    // R10
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !cs_n) |=> $stable(cnt_q));

    // R1
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cs_n) |=> state_q == ST_IDLE);

    // R11
    commit_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o || wcr_load_o) |-> $past(state_q) == ST_CLOSING);

endmodule

// File: rtl/spi_pot_decoder.sv
module spi_pot_decoder
    import spi_pot_pkg::*;
#(
    parameter int         NV_CYCLES = 400,
    parameter logic [7:0] RESET_VAL = 8'h80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    output logic       so,
    output logic       so_oe,
    input  logic       hold_n,
    input  logic       wp_n,
    input  logic [1:0] dev_addr,
    output logic [7:0] wiper_pos
);
    logic [IDX_W-1:0]  rf_raddr, rf_waddr;
    logic [BYTE_W-1:0] rf_rdata, rf_wdata, dr0, wcr_val;
    logic              rf_we, wip, wcr_load, step_up, step_dn;

    spi_pot_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck        (sck),
        .cs_n       (cs_n),
        .si         (si),
        .hold_n     (hold_n),
        .wp_n       (wp_n),
        .dev_addr   (dev_addr),
        .wiper_i    (wiper_pos),
        .rf_rdata_i (rf_rdata),
        .wip_i      (wip),
        .rf_raddr_o (rf_raddr),
        .rf_we_o    (rf_we),
        .rf_waddr_o (rf_waddr),
        .rf_wdata_o (rf_wdata),
        .wcr_load_o (wcr_load),
        .wcr_val_o  (wcr_val),
        .step_up_o  (step_up),
        .step_dn_o  (step_dn),
        .so_o       (so),
        .so_oe_o    (so_oe)
    );

    spi_pot_regfile #(
        .NV_CYCLES (NV_CYCLES),
        .RESET_VAL (RESET_VAL)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (rf_we),
        .waddr_i (rf_waddr),
        .wdata_i (rf_wdata),
        .raddr_i (rf_raddr),
        .rdata_o (rf_rdata),
        .dr0_o   (dr0),
        .wip_o   (wip)
    );

    spi_pot_wiper u_wiper (
        .clk          (clk),
        .rst_n        (rst_n),
        .recall_val_i (dr0),
        .load_i       (wcr_load),
        .load_val_i   (wcr_val),
        .up_i         (step_up),
        .dn_i         (step_dn),
        .pos_o        (wiper_pos)
    );

endmodule

// File: tb/spi_pot_decoder_tb_top.sv
module spi_pot_decoder_tb_top;

    localparam int         NV   = 400;
    localparam logic [7:0] RV   = 8'h80;
    localparam logic [7:0] ID   = 8'h52;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b0;
    logic       si = 1'b0;
    logic       hold_n = 1'b1;
    logic       wp_n = 1'b1;
    logic [1:0] dev_addr = 2'b10;
    logic       so, so_oe;
    logic [7:0] wiper_pos;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    string      tag_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] obs_q[$];

    always #10 clk = ~clk;

    spi_pot_decoder #(.NV_CYCLES(NV), .RESET_VAL(RV)) dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .hold_n(hold_n), .wp_n(wp_n),
        .dev_addr(dev_addr), .wiper_pos(wiper_pos)
    );

    // Monitor: pairs observed results with expected items in order
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && obs_q.size() > 0) begin
                string      t;
                logic [7:0] e;
                logic [7:0] o;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                vectors++;
                if (o !== e) begin
                    miscompares++;
                    $display("FAIL %s actual=%02h expected=%02h", t, o, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(input string t, input logic [7:0] v);
        tag_q.push_back(t);
        exp_q.push_back(v);
    endtask

    task automatic observe(input logic [7:0] v);
        obs_q.push_back(v);
    endtask

    task automatic check_wiper(input string t, input logic [7:0] v);
        expect_item(t, v);
        observe(wiper_pos);
    endtask

    task automatic sbit(input logic b, output logic r);
        si = b;
        tick(3);
        r = so;
        sck = 1'b1;
        tick(4);
        sck = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            sbit(tx[i], b);
            rx[i] = b;
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic cs_hi();
        tick(2);
        cs_n = 1'b1;
        tick(4);
    endtask

    task automatic rd3(input string t, input logic [7:0] id, input logic [7:0] ins,
                       input logic [7:0] ev);
        logic [7:0] r;
        cs_lo();
        sbyte(id, r);
        sbyte(ins, r);
        sbyte(8'h00, r);
        cs_hi();
        expect_item(t, ev);
        observe(r);
    endtask

    task automatic wr3(input logic [7:0] id, input logic [7:0] ins, input logic [7:0] d);
        logic [7:0] r;
        cs_lo();
        sbyte(id, r);
        sbyte(ins, r);
        sbyte(d, r);
        cs_hi();
    endtask

    task automatic wr2(input logic [7:0] ins);
        logic [7:0] r;
        cs_lo();
        sbyte(ID, r);
        sbyte(ins, r);
        cs_hi();
    endtask

    task automatic steps(input logic [7:0] ins, input logic [15:0] pat, input int n);
        logic [7:0] r;
        logic       b;
        cs_lo();
        sbyte(ID, r);
        sbyte(ins, r);
        for (int i = 0; i < n; i++) sbit(pat[i], b);
        cs_hi();
    endtask

    task automatic rd_hold(input logic [7:0] ins, input logic [7:0] ev);
        logic [7:0] r;
        logic       b;
        cs_lo();
        sbyte(ID, r);
        sbyte(ins, r);
        for (int i = 7; i >= 4; i--) begin
            sbit(1'b0, b);
            r[i] = b;
        end
        hold_n = 1'b0;
        tick(3);
        expect_item("R10 so_oe during hold", 8'h00);
        observe({7'b0, so_oe});
        repeat (2) begin
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
            tick(4);
        end
        hold_n = 1'b1;
        tick(3);
        for (int i = 3; i >= 0; i--) begin
            sbit(1'b0, b);
            r[i] = b;
        end
        cs_hi();
        expect_item("R10 read across hold", ev);
        observe(r);
    endtask

    initial begin
        logic [7:0] r;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        check_wiper("R12 wiper recalled from register 0", RV);
        expect_item("R1 so_oe idle", 8'h00);
        observe({7'b0, so_oe});

        // R1: cs low since reset, no falling edge: write must be ignored
        sbyte(ID, r);
        sbyte(8'hA0, r);
        sbyte(8'h11, r);
        cs_hi();
        check_wiper("R1 no frame without cs fall", RV);

        rd3("R3 read wiper", ID, 8'h90, RV);
        wr3(ID, 8'hA0, 8'h3C);
        check_wiper("R4 write wiper", 8'h3C);
        expect_item("R1 so_oe with cs high", 8'h00);
        observe({7'b0, so_oe});

        // R4 / R8: store into bank 2 register 1
        wr3(ID, 8'hC6, 8'hA5);
        rd3("R8 status busy", ID, 8'h51, 8'h01);
        tick(NV + 20);
        rd3("R8 status clear", ID, 8'h51, 8'h00);
        rd3("R4 read back bank2 reg1", ID, 8'hB6, 8'hA5);

        // R9: protect low
        wp_n = 1'b0;
        wr3(ID, 8'hC4, 8'h11);
        wp_n = 1'b1;
        rd3("R9 protected store dropped", ID, 8'hB4, RV);
        rd3("R9 no busy after protected store", ID, 8'h51, 8'h00);

        // R9: store while busy
        wr3(ID, 8'hC1, 8'h12);
        wr3(ID, 8'hC5, 8'h34);
        tick(NV + 20);
        rd3("R9 first store kept", ID, 8'hB1, 8'h12);
        rd3("R9 store during busy dropped", ID, 8'hB5, RV);

        // R2: identification mismatches
        wr3(8'h53, 8'hA0, 8'h00);
        check_wiper("R2 strap mismatch", 8'h3C);
        wr3(8'h42, 8'hA0, 8'h00);
        check_wiper("R2 type mismatch", 8'h3C);
        wr3(8'h5A, 8'hA0, 8'h00);
        check_wiper("R2 reserved bits set", 8'h3C);

        // R6: bank and opcode rejection
        wr3(ID, 8'hA1, 8'h00);
        check_wiper("R6 wiper write bank 01", 8'h3C);
        wr3(ID, 8'hF0, 8'h00);
        check_wiper("R6 undefined opcode", 8'h3C);

        // R5: transfers
        wr2(8'hEC);
        tick(NV + 20);
        rd3("R5 wiper stored to reg3", ID, 8'hBC, 8'h3C);
        wr3(ID, 8'hC8, 8'h77);
        tick(NV + 20);
        wr2(8'hD8);
        check_wiper("R5 reg2 loaded to wiper", 8'h77);
        wr2(8'hD9);
        check_wiper("R6 load with bank 01", 8'h77);

        // R7: stepping
        steps(8'h20, 16'b0111, 4);
        check_wiper("R7 up up up down", 8'h79);
        steps(8'h21, 16'b11, 2);
        check_wiper("R6 step bank 01", 8'h79);
        wr3(ID, 8'hA0, 8'hFE);
        steps(8'h20, 16'b111, 3);
        check_wiper("R7 saturate high", 8'hFF);
        wr3(ID, 8'hA0, 8'h01);
        steps(8'h20, 16'b000, 3);
        check_wiper("R7 saturate low", 8'h00);

        // R11: abort mid-byte
        cs_lo();
        sbyte(ID, r);
        sbyte(8'hA0, r);
        for (int i = 0; i < 4; i++) begin
            logic b;
            sbit(1'b1, b);
        end
        cs_hi();
        check_wiper("R11 aborted write", 8'h00);

        // R10: hold in the middle of a read
        rd_hold(8'hB6, 8'hA5);

        while (exp_q.size() > 0 || obs_q.size() > 0) tick(1);
        tick(2);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog R1-frame run actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule